// File: doc/BRIEF.md
# Pulse-Train Transmitter with Carrier Gating

This block plays a stored list of timed levels out on one pin. A 64-word item memory sits outside the block, and the block reads it through a combinational read port. Each 32-bit word holds two entries. An entry is a level bit and a 15-bit duration counted in divider ticks. The entries are sent in order, low half first. An entry whose duration is zero marks the end of the message.

The block can play the list once or loop over it. It can also run past the last word back to word 0, which lets software refill words that have already been sent. A sent-word counter raises a one-cycle pulse each time a programmed number of words has gone out, and software uses that pulse to pace the refill.

A square carrier with programmable high and low times can be gated onto one chosen level of the waveform. While no transmission is running, the pin shows a configured idle level, and the pin's output enable is configurable separately.

Top module: `pulse_tx`

## Requirements
- R1: Each entry is held on the pin for its duration in ticks. The entry in bits [15:0] (level bit 15, duration bits 14:0) is sent first. The entry in bits [31:16] (level bit 31, duration bits 30:16) is sent next. Words are then taken in increasing address order.
- R2: A tick occurs every `tick_div`+1 clocks, so an entry of duration d lasts d*(`tick_div`+1) clocks.
- R3: When `start` is seen high while idle, `busy` rises on the next edge. The next cycle is a setup cycle in which the pin stays idle, and word 0's first entry appears on the following edge. A `start` seen while busy has no effect on the waveform.
- R4: When the next entry has duration zero and `loop_mode` is low, the transmission ends. On that same edge the pin returns to idle, `busy` falls and `done` rises, and `done` stays high for exactly one cycle.
- R5: When the next entry has duration zero and `loop_mode` is high, the pin shows one idle cycle and playback restarts at word 0, entry [15:0]. If `loop_mode` is cleared, the next zero entry ends the run as in R4.
- R6: When the [31:16] entry of word 63 finishes and `wrap_en` is low, the run ends as in R4. When `wrap_en` is high, playback goes on with word 0 with no gap.
- R7: The block counts completed words, meaning words whose [31:16] entry has finished. When the count reaches `thr_limit` (nonzero), `thr_evt` pulses for one cycle and the count restarts. A limit of 0 gives no pulses, and every `start` clears the count.
- R8: While not busy, and during setup and restart cycles, `tx_out` equals `idle_level` and `tx_oe` equals `idle_oe`. While an entry is playing, `tx_oe` is 1.
- R9: With `car_en` high, the carrier is gated onto entries whose level equals NOT `car_on_low`. The pin is high for max(`car_high`,1) clocks, then low for max(`car_low`,1) clocks, repeating, and this pattern restarts at the start of every entry. Entries of the other level are output unchanged.
- R10: With `car_en` low, the pin carries the raw entry level.
- R11: After reset, `busy`, `done` and `thr_evt` are 0 and `mem_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 6 | Item memory word address |
| mem_data | input | 32 | Item word read combinationally at `mem_addr` |
| tick_div | input | 8 | Tick period minus one, in clocks |
| start | input | 1 | Begin a transmission at word 0 |
| loop_mode | input | 1 | Restart at word 0 on a zero entry |
| wrap_en | input | 1 | Continue from word 63 to word 0 |
| thr_limit | input | 9 | Completed-word count for a threshold pulse (0 = off) |
| idle_level | input | 1 | Pin level when not playing |
| idle_oe | input | 1 | Pin output enable when not playing |
| car_en | input | 1 | Enable carrier gating |
| car_high | input | 16 | Carrier high time in clocks |
| car_low | input | 16 | Carrier low time in clocks |
| car_on_low | input | 1 | 1: carrier on level-0 entries, 0: on level-1 entries |
| tx_out | output | 1 | Pin level |
| tx_oe | output | 1 | Pin output enable |
| busy | output | 1 | Transmission in progress |
| done | output | 1 | One-cycle pulse when a transmission ends |
| thr_evt | output | 1 | One-cycle pulse when the word threshold is reached |

## Verification
The assertions assume two things about the inputs. First, a word is not rewritten while the reader is on it. Second, loop mode is never combined with a zero first entry, which would spin forever in restart cycles. The stimulus respects both. It keeps every non-terminating duration in 1 to 5 and holds the configuration steady through a run. It changes `loop_mode` only during the final pass, and it rewrites memory only in a word the reader has not yet reached again. Random buffers, divider values and carrier settings are mixed with directed cases for an immediate terminator, the end of the buffer, wrap-around refill, looping and a threshold of zero.

// File: rtl/pulse_tx.sv
module pulse_tx #(
  parameter int AW   = 6,
  parameter int DW   = 15,
  parameter int DIVW = 8,
  parameter int LIMW = 9,
  parameter int CW   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [AW-1:0]     mem_addr,
  input  logic [2*DW+1:0]   mem_data,
  input  logic [DIVW-1:0]   tick_div,
  input  logic              start,
  input  logic              loop_mode,
  input  logic              wrap_en,
  input  logic [LIMW-1:0]   thr_limit,
  input  logic              idle_level,
  input  logic              idle_oe,
  input  logic              car_en,
  input  logic [CW-1:0]     car_high,
  input  logic [CW-1:0]     car_low,
  input  logic              car_on_low,
  output logic              tx_out,
  output logic              tx_oe,
  output logic              busy,
  output logic              done,
  output logic              thr_evt
);
  localparam int EW = DW + 1;
  localparam logic [AW-1:0] LAST_ADDR = '1;

  logic            busy_q, ld_q, half_q, lvl_q, done_q, thr_q, cph_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   rem_q;
  logic [DIVW-1:0] divc_q;
  logic [LIMW-1:0] sent_q;
  logic [CW-1:0]   ccnt_q;

  logic            active, tick, seg_end, word_end, buf_end, do_load, sel_hi, zero_ent, thr_hit, modulate;
  logic [EW-1:0]   ent;
  logic [LIMW-1:0] sent_inc;
  logic [CW:0]     ccnt_nx;

  assign active   = busy_q & ~ld_q;
  assign tick     = active & (divc_q == tick_div);
  assign seg_end  = tick & (rem_q == DW'(1));
  assign word_end = seg_end & half_q;
  assign buf_end  = word_end & (addr_q == LAST_ADDR) & ~wrap_en;
  assign mem_addr = word_end ? addr_q + 1'b1 : addr_q;
  assign sel_hi   = ~ld_q & ~half_q;
  assign ent      = sel_hi ? mem_data[2*EW-1:EW] : mem_data[EW-1:0];
  assign zero_ent = (ent[DW-1:0] == '0);
  assign do_load  = busy_q & (ld_q | (seg_end & ~buf_end));
  assign sent_inc = sent_q + 1'b1;
  assign thr_hit  = word_end & (thr_limit != '0) & (sent_inc == thr_limit);
  assign ccnt_nx  = {1'b0, ccnt_q} + 1'b1;
  assign modulate = car_en & (lvl_q != car_on_low);

  assign tx_out  = active ? (modulate ? cph_q : lvl_q) : idle_level;
  assign tx_oe   = active | idle_oe;
  assign busy    = busy_q;
  assign done    = done_q;
  assign thr_evt = thr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; ld_q <= 1'b0; half_q <= 1'b0; lvl_q <= 1'b0;
      done_q <= 1'b0; thr_q <= 1'b0; cph_q <= 1'b1; addr_q <= '0;
      rem_q <= '0; divc_q <= '0; sent_q <= '0; ccnt_q <= '0;
    end else begin
      done_q <= 1'b0;
      thr_q  <= thr_hit;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1; ld_q <= 1'b1; addr_q <= '0; half_q <= 1'b0; sent_q <= '0;
        end
      end else begin
        if (word_end) sent_q <= thr_hit ? '0 : sent_inc;
        if (active) begin
          divc_q <= tick ? '0 : divc_q + 1'b1;
          if (tick) rem_q <= rem_q - 1'b1;
          if (cph_q) begin
            if (ccnt_nx >= {1'b0, car_high}) begin cph_q <= 1'b0; ccnt_q <= '0; end
            else ccnt_q <= ccnt_nx[CW-1:0];
          end else begin
            if (ccnt_nx >= {1'b0, car_low}) begin cph_q <= 1'b1; ccnt_q <= '0; end
            else ccnt_q <= ccnt_nx[CW-1:0];
          end
        end
        if (seg_end) begin
          half_q <= ~half_q;
          if (half_q) addr_q <= addr_q + 1'b1;
        end
        if (buf_end) begin
          busy_q <= 1'b0; done_q <= 1'b1; addr_q <= '0; half_q <= 1'b0; ld_q <= 1'b0;
        end else if (do_load) begin
          ld_q <= 1'b0;
          if (zero_ent) begin
            addr_q <= '0; half_q <= 1'b0;
            if (loop_mode) ld_q <= 1'b1;
            else begin busy_q <= 1'b0; done_q <= 1'b1; end
          end else begin
            lvl_q <= ent[DW]; rem_q <= ent[DW-1:0]; divc_q <= '0;
            cph_q <= 1'b1; ccnt_q <= '0;
          end
        end
      end
    end
  end

  // R3
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);
  // R4
  done_ends_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  thr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_evt |=> !thr_evt);
  // R1
  live_entry_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (rem_q != '0));
  // R11
  done_addr_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mem_addr == '0));
endmodule

// File: tb/tb_pulse_tx.sv
`timescale 1ns/1ps
module tb_pulse_tx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] mem_addr;
  logic [31:0] mem_data;
  logic [7:0] tick_div = 8'd0;
  logic start = 1'b0, loop_mode = 1'b0, wrap_en = 1'b0;
  logic [8:0] thr_limit = 9'd0;
  logic idle_level = 1'b1, idle_oe = 1'b1, car_en = 1'b0, car_on_low = 1'b0;
  logic [15:0] car_high = 16'd1, car_low = 16'd1;
  logic tx_out, tx_oe, busy, done, thr_evt;
  logic [31:0] mem [64];
  int checks = 0, fails = 0;

  assign mem_data = mem[mem_addr];
  always #2.5 clk = ~clk;

  pulse_tx dut (.clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_data(mem_data),
    .tick_div(tick_div), .start(start), .loop_mode(loop_mode), .wrap_en(wrap_en),
    .thr_limit(thr_limit), .idle_level(idle_level), .idle_oe(idle_oe), .car_en(car_en),
    .car_high(car_high), .car_low(car_low), .car_on_low(car_on_low), .tx_out(tx_out),
    .tx_oe(tx_oe), .busy(busy), .done(done), .thr_evt(thr_evt));

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_out(bit lvl, int k);
    int hh = (car_high == 0) ? 1 : int'(car_high);
    int ll = (car_low == 0) ? 1 : int'(car_low);
    if (car_en && (lvl != car_on_low)) return (k % (hh + ll)) < hh;
    return lvl;
  endfunction

  function automatic logic [15:0] ent(bit l, int d);
    return {l, 15'(d)};
  endfunction

  task automatic run_tx(input int passes, input bit poke, input bit hook, input string tag);
    int a = 0, h = 0, words = 0, thr_seen = 0, pass = 1, p = int'(tick_div) + 1;
    bit fin = 0, first = 1;
    loop_mode = (passes > 1);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    // R3 R8: setup cycle keeps the pin idle
    chk(busy && tx_oe == idle_oe && tx_out == idle_level, "R3", {tag, " setup"},
        int'({busy, tx_oe, tx_out}), int'({1'b1, idle_oe, idle_level}));
    @(negedge clk);
    while (!fin) begin
      logic [31:0] w = mem[a];
      logic [15:0] e = h ? w[31:16] : w[15:0];
      if (e[14:0] == 0) begin
        if (pass < passes) begin
          // R5: one idle cycle then replay from word 0
          thr_seen += int'(thr_evt);
          chk(busy && tx_oe == idle_oe && tx_out == idle_level, "R5", {tag, " restart gap"},
              int'({busy, tx_oe, tx_out}), int'({1'b1, idle_oe, idle_level}));
          @(negedge clk);
          a = 0; h = 0; pass++;
          if (pass == passes) loop_mode = 1'b0;
        end else fin = 1;
      end else begin
        int len = int'(e[14:0]) * p, bad_k = -1, act = 0, ex = 0;
        for (int k = 0; k < len; k++) begin
          bit x = exp_out(e[15], k);
          thr_seen += int'(thr_evt);
          if ((tx_out !== x || tx_oe !== 1'b1) && bad_k < 0) begin
            bad_k = k; act = int'({tx_oe, tx_out}); ex = int'({1'b1, x});
          end
          start = poke && first && k == 0;
          @(negedge clk);
        end
        start = 1'b0; first = 0;
        // R1 R2 R9 R10: whole entry matches level, duration and carrier
        chk(bad_k < 0, "R1/R2/R9/R10", $sformatf("%s word %0d half %0d", tag, a, h), act, ex);
        if (h == 1) begin
          words++; a++;
          if (a == 64) begin
            if (wrap_en) begin a = 0; if (hook) mem[2] = 32'h0; end
            else fin = 1;
          end
        end
        h ^= 1;
      end
    end
    // R4 R6: end edge drops busy and raises done
    thr_seen += int'(thr_evt);
    chk(done && !busy && tx_oe == idle_oe && tx_out == idle_level, "R4/R6", {tag, " end"},
        int'({done, busy, tx_oe, tx_out}), int'({1'b1, 1'b0, idle_oe, idle_level}));
    @(negedge clk);
    thr_seen += int'(thr_evt);
    chk(!done, "R4", {tag, " done width"}, int'(done), 0);
    // R7
    chk(thr_seen == ((thr_limit == 0) ? 0 : words / int'(thr_limit)), "R7", {tag, " thr pulses"},
        thr_seen, (thr_limit == 0) ? 0 : words / int'(thr_limit));
  endtask

  task automatic fill_rand(int t, bit th);
    for (int i = 0; i < 64; i++)
      mem[i] = {ent(1'($urandom), 1 + $urandom % 5), ent(1'($urandom), 1 + $urandom % 5)};
    if (th) mem[t][30:16] = '0; else mem[t][14:0] = '0;
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 R8
    chk(!busy && !done && !thr_evt && mem_addr == 0, "R11", "reset state",
        int'({busy, done, thr_evt}), 0);
    chk(tx_oe == 1'b1 && tx_out == 1'b1, "R8", "idle pin", int'({tx_oe, tx_out}), 3);

    // R4: immediate terminator
    idle_level = 1'b0; idle_oe = 1'b0;
    run_tx(1, 0, 0, "empty");

    // R1 R10: directed order of halves, carrier off, divider 0
    mem[0] = {ent(0, 2), ent(1, 3)}; mem[1] = {ent(1, 1), ent(0, 4)}; mem[2] = {ent(1, 0), ent(1, 2)};
    run_tx(1, 1, 0, "directed");

    // R2 R9: carrier on level 1, divider 2
    tick_div = 8'd2; car_en = 1'b1; car_high = 16'd2; car_low = 16'd3; car_on_low = 1'b0;
    mem[0] = {ent(0, 3), ent(1, 4)}; mem[1] = {ent(0, 0), ent(1, 2)};
    run_tx(1, 0, 0, "carrier hi");
    // R9: carrier on level 0, zero counts act as one clock
    car_on_low = 1'b1; car_high = 16'd0; car_low = 16'd0;
    run_tx(1, 0, 0, "carrier lo");

    // R6 R7: full buffer without wrap ends after word 63
    car_en = 1'b0; tick_div = 8'd0; thr_limit = 9'd10; wrap_en = 1'b0;
    for (int i = 0; i < 64; i++) mem[i] = {ent(i[0], 1), ent(~i[0], 1 + i % 3)};
    run_tx(1, 0, 0, "buf end");

    // R6 R7: wrap with refill of word 2 as terminator
    wrap_en = 1'b1; thr_limit = 9'd20;
    run_tx(1, 0, 1, "wrap");
    wrap_en = 1'b0;

    // R5: loop three passes, terminator in word 3 upper half
    thr_limit = 9'd4;
    fill_rand(3, 1);
    run_tx(3, 0, 0, "loop");

    // R7: threshold zero gives no pulses
    thr_limit = 9'd0;
    fill_rand(5, 0);
    run_tx(1, 0, 0, "thr off");

    // random runs
    for (int r = 0; r < 10; r++) begin
      tick_div = 8'($urandom % 3); car_en = 1'($urandom); car_on_low = 1'($urandom);
      car_high = 16'($urandom % 5); car_low = 16'($urandom % 5);
      idle_level = 1'($urandom); idle_oe = 1'($urandom); thr_limit = 9'($urandom % 8);
      fill_rand(1 + $urandom % 12, 1'($urandom));
      run_tx((r % 4 == 3) ? 2 : 1, 1'($urandom), 0, $sformatf("rand%0d", r));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule